// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a synthesizable model of an asynchronous word-wide static RAM for use inside a larger design or an emulation build. The word is split into byte lanes. There are two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low strobe per byte lane. The block decodes these controls, for each lane, into idle, read or write. A lane that is reading drives its byte of the addressed word. A lane that is writing stores the byte present on the data inputs when the write ends.

The controls arrive without any clock relation. The model samples them with a free-running clock that runs much faster than the access rate, so timing is kept only as event order. Each lane keeps the last address and data byte it sampled while its write was active. It commits that byte on the first clock edge that finds its write over, whichever control ended it. Inside a chip there are no tri-state nets, so the pad's three-state buffer is split into a data-in bus, a data-out bus and one drive flag per lane. The default depth is 2**10 words. Setting ADDR_W to 16 gives the full 64K-word part.

Top module: `sram_model`

## Requirements
- R1: The array holds 2**ADDR_W words of LANES*BYTE_W bits. A full-word write to any address, including address 0 and the last address, reads back unchanged.
- R2: When `csel_lo_n` is 1 or `csel_hi` is 0, the device is deselected. `dq_drive` is 2'b00, `dq_out` is zero, and no write takes place whatever the other inputs are.
- R3: When the device is selected and all of `lane_en_n` are 1, the device is in standby. No lane is driven and nothing is written.
- R4: A read occurs when the device is selected, `wr_en_n` is 1 and `out_en_n` is 0. Lane i (bit i of `lane_en_n` and `dq_drive`; lane 0 is `dq_out[7:0]`, lane 1 is `dq_out[15:8]`) is driven with the stored byte only when `lane_en_n[i]` is 0. The byte of an undriven lane reads as zero.
- R5: When the device is selected with `wr_en_n` at 1 and `out_en_n` at 1, the outputs are disabled and no lane is driven.
- R6: When the device is selected with `wr_en_n` at 0, the access is a write whatever `out_en_n` is, and neither lane is driven during it.
- R7: Only lanes whose strobe is 0 are written. The other byte of the addressed word keeps its old value.
- R8: The committed byte is the `dq_in` value sampled at the last clock edge that found the write active. A data change made together with the edge that ends the write is not stored.
- R9: Any qualifier that goes inactive ends a lane's write: `wr_en_n` rising, `csel_lo_n` rising, `csel_hi` falling, or the lane's own strobe rising. Each lane ends on its own, so one lane may commit while the other keeps writing.
- R10: A write is committed on the first rising clock edge that samples it as ended. Before that edge a read returns the old byte, and after it the read returns the new byte.
- R11: While `rst_n` is 0, and until it has been released for two clock edges, no lane is driven and no write is tracked. A write cut off by reset is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the access rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | input | ADDR_W | Word address |
| csel_lo_n | input | 1 | Active-low chip select |
| csel_hi | input | 1 | Active-high chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_en_n | input | LANES | Active-low byte strobes, bit 0 is the low byte |
| dq_in | input | LANES*BYTE_W | Data from the pad towards the array |
| dq_out | output | LANES*BYTE_W | Read data, zero on undriven lanes |
| dq_drive | output | LANES | Per-lane pad drive enable |

## Verification
The assertions check the drive side on every cycle: no lane is driven while the device is deselected, in standby, in a write or with outputs disabled, and a read drives exactly the lanes whose strobes are low. What ends up in the array can only be seen through the bench's scenarios. Those cover byte merging, which data sample a write keeps, the four ways a write can end (including lanes ending separately), the clock edge at which a commit shows up, and writes cut off by reset. They also cover every control combination checked against a reference array.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE  = 2'd0,
    LANE_READ  = 2'd1,
    LANE_WRITE = 2'd2
  } lane_mode_e;

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   run,
  input  logic                   csel_lo_n,
  input  logic                   csel_hi,
  input  logic                   out_en_n,
  input  logic                   wr_en_n,
  input  logic [LANES-1:0]       lane_en_n,
  output lane_mode_e [LANES-1:0] lane_mode
);

  logic chip_on;

  assign chip_on = run & ~csel_lo_n & csel_hi;

  // One decoder per lane: a lane is only active when its own strobe is low.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!chip_on || lane_en_n[g]) begin
        lane_mode[g] = LANE_IDLE;
      end else if (!wr_en_n) begin
        lane_mode[g] = LANE_WRITE;   // output enable has no say here
      end else if (!out_en_n) begin
        lane_mode[g] = LANE_READ;
      end else begin
        lane_mode[g] = LANE_IDLE;
      end
    end
  end

endmodule

// File: rtl/sram_write_track.sv
module sram_write_track
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                               clk,
  input  logic                               run_n,
  input  lane_mode_e [LANES-1:0]             lane_mode,
  input  logic [ADDR_W-1:0]                  mem_addr,
  input  logic [LANES*BYTE_W-1:0]            dq_in,
  output logic [LANES-1:0]                   commit,
  output logic [LANES-1:0][ADDR_W-1:0]       commit_addr,
  output logic [LANES-1:0][BYTE_W-1:0]       commit_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              act;
    logic              act_d;
    logic              act_q;
    logic              cap_en;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    // next state
    always_comb begin
      act    = (lane_mode[g] == LANE_WRITE);
      act_d  = act;
      cap_en = act;
    end

    // write-in-progress flag, cleared by reset
    always_ff @(posedge clk or negedge run_n) begin
      if (!run_n) begin
        act_q <= 1'b0;
      end else begin
        act_q <= act_d;
      end
    end

    // last sample taken while the write was open
    always_ff @(posedge clk) begin
      if (cap_en) begin
        addr_q <= mem_addr;
        data_q <= dq_in[g*BYTE_W +: BYTE_W];
      end
    end

    // the edge that first sees the write gone is the commit edge
    assign commit[g]      = act_q & ~act;
    assign commit_addr[g] = addr_q;
    assign commit_data[g] = data_q;

    // R10: a commit is a single-cycle event per ended write
    a_r10_commit_one_shot: assert property (@(posedge clk) disable iff (!run_n)
      commit[g] |=> !commit[g]);
  end

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                         clk,
  input  logic [LANES-1:0]             commit,
  input  logic [LANES-1:0][ADDR_W-1:0] commit_addr,
  input  logic [LANES-1:0][BYTE_W-1:0] commit_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [LANES-1:0][BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // separate storage per lane, so each lane may commit to its own address
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (commit[g]) begin
        cells[commit_addr[g]] <= commit_data[g];
      end
    end

    assign rd_data[g] = cells[rd_addr];
  end

endmodule

// File: rtl/sram_model.sv
module sram_model
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       mem_addr,
  input  logic                    csel_lo_n,
  input  logic                    csel_hi,
  input  logic                    out_en_n,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*BYTE_W-1:0] dq_in,
  output logic [LANES*BYTE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_drive
);

  localparam int DATA_W = LANES * BYTE_W;

  logic [1:0]                   rst_pipe;
  logic                         run;
  lane_mode_e [LANES-1:0]       lane_mode;
  logic [LANES-1:0]             commit;
  logic [LANES-1:0][ADDR_W-1:0] commit_addr;
  logic [LANES-1:0][BYTE_W-1:0] commit_data;
  logic [LANES-1:0][BYTE_W-1:0] rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign run = rst_pipe[1];

  sram_lane_decode #(.LANES(LANES)) decode_i (
    .run       (run),
    .csel_lo_n (csel_lo_n),
    .csel_hi   (csel_hi),
    .out_en_n  (out_en_n),
    .wr_en_n   (wr_en_n),
    .lane_en_n (lane_en_n),
    .lane_mode (lane_mode)
  );

  sram_write_track #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) track_i (
    .clk         (clk),
    .run_n       (run),
    .lane_mode   (lane_mode),
    .mem_addr    (mem_addr),
    .dq_in       (dq_in),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  sram_lane_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) store_i (
    .clk         (clk),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .rd_addr     (mem_addr),
    .rd_data     (rd_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_drive[g]                = (lane_mode[g] == LANE_READ);
    assign dq_out[g*BYTE_W +: BYTE_W] = dq_drive[g] ? rd_data[g] : '0;
  end

  // R2: a deselected device keeps every lane quiet
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!run)
    (csel_lo_n || !csel_hi) |-> (dq_drive == '0 && dq_out == DATA_W'(0)));

  // R3: standby when all strobes are high
  a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!run)
    (&lane_en_n) |-> (dq_drive == '0));

  // R5: selected, not writing, output enable high
  a_r5_outputs_off: assert property (@(posedge clk) disable iff (!run)
    (wr_en_n && out_en_n) |-> (dq_drive == '0));

  // R6: never drive the pads while write enable is low
  a_r6_write_floats: assert property (@(posedge clk) disable iff (!run)
    (!wr_en_n) |-> (dq_drive == '0));

  // R4: a read drives exactly the strobed lanes
  a_r4_read_lanes: assert property (@(posedge clk) disable iff (!run)
    (!csel_lo_n && csel_hi && wr_en_n && !out_en_n) |-> (dq_drive == ~lane_en_n));

endmodule

// File: tb/sram_model_tb.sv
module sram_model_tb_top;

  localparam int AW = 10;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          csel_lo_n;
  logic          csel_hi;
  logic          out_en_n;
  logic          wr_en_n;
  logic [1:0]    lane_en_n;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out;
  logic [1:0]    dq_drive;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] ref_mem [1 << AW];

  sram_model #(.ADDR_W(AW), .BYTE_W(8), .LANES(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .csel_lo_n (csel_lo_n),
    .csel_hi   (csel_hi),
    .out_en_n  (out_en_n),
    .wr_en_n   (wr_en_n),
    .lane_en_n (lane_en_n),
    .dq_in     (dq_in),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic wrap_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=completion");
    wrap_up();
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic l_n, input logic h, input logic oe_n, input logic we_n,
                       input logic [1:0] st, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    csel_lo_n = l_n; csel_hi = h; out_en_n = oe_n; wr_en_n = we_n;
    lane_en_n = st; mem_addr = a; dq_in = d;
  endtask

  task automatic idle();
    apply(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, mem_addr, dq_in);
  endtask

  task automatic ref_put(input logic [AW-1:0] a, input logic [1:0] st, input logic [15:0] d);
    if (!st[0]) ref_mem[a][7:0]  = d[7:0];
    if (!st[1]) ref_mem[a][15:8] = d[15:8];
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] st);
    apply(1'b0, 1'b1, 1'b1, 1'b0, st, a, d);
    apply(1'b0, 1'b1, 1'b1, 1'b1, st, a, d);
    idle();
    ref_put(a, st, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [1:0] st, input string tag);
    logic [15:0] e;
    logic [1:0]  ed;
    apply(1'b0, 1'b1, 1'b0, 1'b1, st, a, 16'h0000);
    #1;
    ed = ~st;
    e  = ref_mem[a];
    if (st[0]) e[7:0]  = 8'h00;
    if (st[1]) e[15:8] = 8'h00;
    chk(dq_drive == ed, tag, {14'b0, dq_drive}, {14'b0, ed});
    chk(dq_out == e, tag, dq_out, e);
    idle();
  endtask

  // R11: reset keeps pads quiet and drops a pending write
  task automatic t_reset();
    csel_lo_n = 1'b0; csel_hi = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b1;
    lane_en_n = 2'b00; mem_addr = '0; dq_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(dq_drive == 2'b00, "R11 drive in reset", {14'b0, dq_drive}, 16'h0);
    chk(dq_out == 16'h0, "R11 data in reset", dq_out, 16'h0);
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(10'd77, 16'h1357, 2'b00);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd77, 16'hDEAD);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(10'd77, 2'b00, "R11 aborted write");
  endtask

  // R1: full words at both ends and the middle
  task automatic t_basic();
    wr(10'd0, 16'hA1B2, 2'b00);
    wr(10'd1023, 16'h3C4D, 2'b00);
    wr(10'd512, 16'hFFFF, 2'b00);
    wr(10'd513, 16'h0000, 2'b00);
    rd_chk(10'd0, 2'b00, "R1 addr0");
    rd_chk(10'd1023, 2'b00, "R1 last");
    rd_chk(10'd512, 2'b00, "R1 ones");
    rd_chk(10'd513, 2'b00, "R1 zeros");
  endtask

  // R7: byte merging
  task automatic t_bytes();
    wr(10'd20, 16'hA5C3, 2'b00);
    wr(10'd20, 16'h7E00, 2'b01);
    rd_chk(10'd20, 2'b00, "R7 upper only");
    wr(10'd20, 16'h0099, 2'b10);
    rd_chk(10'd20, 2'b00, "R7 lower only");
    rd_chk(10'd20, 2'b01, "R4 upper lane read");
    rd_chk(10'd20, 2'b10, "R4 lower lane read");
  endtask

  // R6: output enable low during a write
  task automatic t_oe_ignored();
    apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd30, 16'h2468);
    #1;
    chk(dq_drive == 2'b00, "R6 float while writing", {14'b0, dq_drive}, 16'h0);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 10'd30, 16'h2468);
    idle();
    ref_put(10'd30, 2'b00, 16'h2468);
    rd_chk(10'd30, 2'b00, "R6 write with oe low");
  endtask

  // R8: last data sample before the end wins
  task automatic t_data_sample();
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd40, 16'h1111);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd40, 16'h2222);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 10'd40, 16'h2222);
    idle();
    ref_put(10'd40, 2'b00, 16'h2222);
    rd_chk(10'd40, 2'b00, "R8 data changed mid write");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd41, 16'h3333);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 10'd41, 16'h4444);
    idle();
    ref_put(10'd41, 2'b00, 16'h3333);
    rd_chk(10'd41, 2'b00, "R8 data changed at end");
  endtask

  // R9: every qualifier can end the write
  task automatic t_terminators();
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd50, 16'hAB01);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 10'd50, 16'hAB01);
    idle();
    ref_put(10'd50, 2'b00, 16'hAB01);
    rd_chk(10'd50, 2'b00, "R9 ended by low select");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd51, 16'hAB02);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd51, 16'hAB02);
    idle();
    ref_put(10'd51, 2'b00, 16'hAB02);
    rd_chk(10'd51, 2'b00, "R9 ended by high select");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd52, 16'hAB03);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 10'd52, 16'hAB03);
    idle();
    ref_put(10'd52, 2'b00, 16'hAB03);
    rd_chk(10'd52, 2'b00, "R9 ended by strobes");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd53, 16'h1234);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 10'd53, 16'h5678);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 10'd53, 16'h5678);
    idle();
    ref_mem[10'd53] = 16'h5634;
    rd_chk(10'd53, 2'b00, "R9 lanes end apart");
  endtask

  // R10: commit becomes visible at the edge that sees the end
  task automatic t_commit_edge();
    wr(10'd60, 16'h0F0F, 2'b00);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd60, 16'hF0F0);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd60, 16'hF0F0);
    #1;
    chk(dq_out == 16'h0F0F, "R10 before commit edge", dq_out, 16'h0F0F);
    @(posedge clk);
    #1;
    chk(dq_out == 16'hF0F0, "R10 after commit edge", dq_out, 16'hF0F0);
    idle();
    ref_put(10'd60, 2'b00, 16'hF0F0);
  endtask

  // R2 R3 R4 R5: every control combination with write enable high
  task automatic t_read_sweep();
    logic [15:0] e;
    logic [1:0]  ed;
    wr(10'd70, 16'h5AA5, 2'b00);
    for (int c = 0; c < 32; c++) begin
      logic [4:0] v;
      logic sel;
      v = 5'(c);
      apply(v[4], v[3], v[2], 1'b1, v[1:0], 10'd70, 16'hFFFF);
      #1;
      sel = !v[4] && v[3];
      ed  = (sel && !v[2]) ? ~v[1:0] : 2'b00;
      e   = ref_mem[10'd70];
      if (!ed[0]) e[7:0]  = 8'h00;
      if (!ed[1]) e[15:8] = 8'h00;
      chk(dq_drive == ed, !sel ? "R2 sweep drive" : (v[1:0] == 2'b11) ? "R3 sweep drive" :
          v[2] ? "R5 sweep drive" : "R4 sweep drive", {14'b0, dq_drive}, {14'b0, ed});
      chk(dq_out == e, "R4 sweep data", dq_out, e);
    end
    idle();
  endtask

  // R2 R3 R6 R7: every control combination with write enable low
  task automatic t_write_sweep();
    wr(10'd80, 16'h0000, 2'b00);
    for (int c = 0; c < 32; c++) begin
      logic [4:0]  v;
      logic [15:0] d;
      logic        sel;
      v   = 5'(c);
      d   = {3'b101, v, 3'b011, v};
      sel = !v[4] && v[3];
      apply(v[4], v[3], v[2], 1'b0, v[1:0], 10'd80, d);
      #1;
      chk(dq_drive == 2'b00, "R6 sweep no drive", {14'b0, dq_drive}, 16'h0);
      idle();
      if (sel) ref_put(10'd80, v[1:0], d);
      rd_chk(10'd80, 2'b00, !sel ? "R2 sweep no write" :
             (v[1:0] == 2'b11) ? "R3 sweep no write" : "R7 sweep lanes");
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bytes();
    t_oe_ignored();
    t_data_sample();
    t_terminators();
    t_commit_edge();
    t_read_sweep();
    t_write_sweep();
    repeat (2) @(negedge clk);
    wrap_up();
  end

endmodule